// File: doc/BRIEF.md
# Voltage-Loop Proportional-Integral Regulator

This block closes the output-voltage loop of a multilevel inverter. On each one-cycle sample strobe it takes an 8-bit unsigned reference sample from a sine table and an 8-bit unsigned measurement of the inverter output voltage. It forms the signed error between the two. A trapezoidal integrator combines the current error with the error of the previous accepted sample, and the block produces an 8-bit unsigned control value. That value sets the modulation amplitude of the PWM stage.

Both gains are fixed at design time. The proportional gain is 10. The integral step weight is a power of two that the accumulator's fractional bits set. The integrator saturates at a fixed bound, so a long run of one-signed error cannot wind it up beyond that bound. The final sum is clamped into the unsigned output range. A three-stage pipeline produces the result, and a one-cycle valid pulse marks it.

Top module: `pi_voltage_reg`

## Requirements
- R1: While reset is asserted, and after it is released, ctl_out is 0 and ctl_vld is 0. Reset also clears the integrator and the stored previous error, so the first sample after reset integrates its error against a previous error of 0.
- R2: The error is ref_smp minus meas_smp. Both inputs are read as unsigned, and the error is a 9-bit signed value in the range -255 to +255.
- R3: The proportional contribution is exactly 10 times the error.
- R4: On each accepted sample the 24-bit signed accumulator adds the current error plus the previous accepted error. One accumulator LSB equals 2^-12 of an output LSB. The integral contribution is the accumulator shifted arithmetically right by 12 bits, which is the floor of the accumulator divided by 4096.
- R5: The accumulator is held within +/-(255*4096). An update that would cross a bound leaves the accumulator at that bound.
- R6: ctl_out is the proportional term plus the integral term, clamped to 0 when the sum is negative and to 255 when the sum is above 255.
- R7: A samp_vld pulse sampled at clock edge k gives ctl_vld high for exactly one cycle following edge k+2. ctl_vld is never high at any other time.
- R8: Between valid pulses ctl_out holds its value. With no strobe, the accumulator and the stored previous error do not change, however long the gap lasts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| samp_vld | input | 1 | One-cycle strobe marking a new sample pair |
| ref_smp | input | 8 | Reference sample, unsigned |
| meas_smp | input | 8 | Measured output voltage, unsigned |
| ctl_out | output | 8 | Saturated control value, unsigned |
| ctl_vld | output | 1 | One-cycle pulse marking a new ctl_out |

## Verification
The states that are hardest to reach from the ports are the two integrator bounds. Each integrator bound needs on the order of two thousand samples of large error of one sign before the clamp engages. While that happens the output sits pinned at 0 or 255, so nothing at the ports reveals where the accumulator is. The stimulus drives long runs of full-scale positive error and then full-scale negative error. It then applies small errors of the opposite sign, which move the output off its rail only by the amount the clamped accumulator allows. An integrator without a clamp would give a visibly different value there. Random samples with random idle gaps cover ordinary operation and check that the held state survives the gaps.

// File: rtl/pi_reg_pkg.sv
package pi_reg_pkg;
  localparam int SMP_W_D   = 8;
  localparam int ACC_W_D   = 24;
  localparam int FRAC_W_D  = 12;
  localparam int KP_D      = 10;
  localparam int INT_LIM_D = 255;
  localparam int OUT_W_D   = 8;
endpackage

// File: rtl/pi_err_stage.sv
module pi_err_stage #(
  parameter int SMP_W = 8,
  localparam int ERR_W = SMP_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    samp_vld,
  input  logic [SMP_W-1:0]        ref_smp,
  input  logic [SMP_W-1:0]        meas_smp,
  output logic signed [ERR_W-1:0] err_q,
  output logic                    err_vld
);
  function automatic logic signed [ERR_W-1:0] diff_of(input logic [SMP_W-1:0] r,
                                                      input logic [SMP_W-1:0] m);
    return $signed({1'b0, r}) - $signed({1'b0, m});
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q   <= '0;
      err_vld <= 1'b0;
    end else begin
      err_vld <= samp_vld;
      if (samp_vld) err_q <= diff_of(ref_smp, meas_smp);
    end
  end

  AST_ERR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !samp_vld |=> $stable(err_q)); // R8
endmodule

// File: rtl/pi_integrator.sv
module pi_integrator #(
  parameter int ERR_W   = 9,
  parameter int ACC_W   = 24,
  parameter int FRAC_W  = 12,
  parameter int INT_LIM = 255
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    upd,
  input  logic signed [ERR_W-1:0] err_in,
  output logic signed [ACC_W-1:0] acc_q,
  output logic signed [ERR_W-1:0] err_d,
  output logic                    acc_vld
);
  localparam logic signed [ACC_W:0] LIM  = (ACC_W+1)'(INT_LIM) <<< FRAC_W;
  localparam logic signed [ACC_W:0] NLIM = -LIM;

  logic signed [ERR_W-1:0] e_prev;
  logic signed [ERR_W:0]   step;
  logic signed [ACC_W:0]   acc_raw;
  logic                    clamp_hi, clamp_lo;
  logic signed [ACC_W-1:0] acc_nxt;

  function automatic logic signed [ERR_W:0] trap_sum(input logic signed [ERR_W-1:0] a,
                                                     input logic signed [ERR_W-1:0] b);
    return (ERR_W+1)'(a) + (ERR_W+1)'(b);
  endfunction

  always_comb begin
    step     = trap_sum(err_in, e_prev);
    acc_raw  = (ACC_W+1)'(acc_q) + (ACC_W+1)'(step);
    clamp_hi = acc_raw > LIM;
    clamp_lo = acc_raw < NLIM;
    if (clamp_hi)      acc_nxt = LIM[ACC_W-1:0];
    else if (clamp_lo) acc_nxt = NLIM[ACC_W-1:0];
    else               acc_nxt = acc_raw[ACC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q   <= '0;
      e_prev  <= '0;
      err_d   <= '0;
      acc_vld <= 1'b0;
    end else begin
      acc_vld <= upd;
      if (upd) begin
        acc_q  <= acc_nxt;
        e_prev <= err_in;
        err_d  <= err_in;
      end
    end
  end

  AST_ACC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ((ACC_W+1)'(acc_q) <= LIM) && ((ACC_W+1)'(acc_q) >= NLIM)); // R5
  AST_ACC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(acc_q) && $stable(e_prev)); // R8
  AST_CLAMP_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && clamp_hi) |=> ((ACC_W+1)'(acc_q) == LIM)); // R5
  AST_CLAMP_LO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && clamp_lo) |=> ((ACC_W+1)'(acc_q) == NLIM)); // R5
endmodule

// File: rtl/pi_output_stage.sv
module pi_output_stage #(
  parameter int ERR_W  = 9,
  parameter int ACC_W  = 24,
  parameter int FRAC_W = 12,
  parameter int KP     = 10,
  parameter int OUT_W  = 8,
  localparam int P_W   = ERR_W + $clog2(KP + 1),
  localparam int I_W   = ACC_W - FRAC_W,
  localparam int SUM_W = ((P_W > I_W) ? P_W : I_W) + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_vld,
  input  logic signed [ERR_W-1:0] err_in,
  input  logic signed [ACC_W-1:0] acc_in,
  output logic [OUT_W-1:0]        ctl_out,
  output logic                    ctl_vld
);
  localparam logic signed [SUM_W-1:0] KP_S    = SUM_W'(KP);
  localparam logic signed [SUM_W-1:0] OUT_MAX = SUM_W'((1 << OUT_W) - 1);

  logic signed [SUM_W-1:0] p_term, i_term, total;
  logic [OUT_W-1:0]        sat_val;

  function automatic logic [OUT_W-1:0] sat_range(input logic signed [SUM_W-1:0] s);
    if (s < 0)            return '0;
    else if (s > OUT_MAX) return OUT_MAX[OUT_W-1:0];
    else                  return s[OUT_W-1:0];
  endfunction

  always_comb begin
    p_term  = SUM_W'(err_in) * KP_S;
    i_term  = SUM_W'($signed(acc_in[ACC_W-1:FRAC_W]));
    total   = p_term + i_term;
    sat_val = sat_range(total);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_out <= '0;
      ctl_vld <= 1'b0;
    end else begin
      ctl_vld <= in_vld;
      if (in_vld) ctl_out <= sat_val;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_vld |-> $stable(ctl_out)); // R8
  AST_OUT_RAIL_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && total > OUT_MAX) |=> (ctl_out == OUT_MAX[OUT_W-1:0])); // R6
  AST_OUT_RAIL_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && total < 0) |=> (ctl_out == '0)); // R6
endmodule

// File: rtl/pi_voltage_reg.sv
module pi_voltage_reg
  import pi_reg_pkg::*;
#(
  parameter int SMP_W   = SMP_W_D,
  parameter int ACC_W   = ACC_W_D,
  parameter int FRAC_W  = FRAC_W_D,
  parameter int KP      = KP_D,
  parameter int INT_LIM = INT_LIM_D,
  parameter int OUT_W   = OUT_W_D,
  localparam int ERR_W  = SMP_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             samp_vld,
  input  logic [SMP_W-1:0] ref_smp,
  input  logic [SMP_W-1:0] meas_smp,
  output logic [OUT_W-1:0] ctl_out,
  output logic             ctl_vld
);
  logic signed [ERR_W-1:0] err_s1, err_s2;
  logic signed [ACC_W-1:0] acc_s2;
  logic                    vld_s1, vld_s2;

  pi_err_stage #(.SMP_W(SMP_W)) u_err (
    .clk(clk), .rst_n(rst_n), .samp_vld(samp_vld),
    .ref_smp(ref_smp), .meas_smp(meas_smp),
    .err_q(err_s1), .err_vld(vld_s1));

  pi_integrator #(.ERR_W(ERR_W), .ACC_W(ACC_W), .FRAC_W(FRAC_W), .INT_LIM(INT_LIM)) u_int (
    .clk(clk), .rst_n(rst_n), .upd(vld_s1), .err_in(err_s1),
    .acc_q(acc_s2), .err_d(err_s2), .acc_vld(vld_s2));

  pi_output_stage #(.ERR_W(ERR_W), .ACC_W(ACC_W), .FRAC_W(FRAC_W), .KP(KP), .OUT_W(OUT_W)) u_out (
    .clk(clk), .rst_n(rst_n), .in_vld(vld_s2), .err_in(err_s2), .acc_in(acc_s2),
    .ctl_out(ctl_out), .ctl_vld(ctl_vld));

  AST_VLD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    samp_vld |=> ##2 ctl_vld); // R7
  AST_VLD_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_vld |-> $past(samp_vld, 3)); // R7
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (ctl_out == '0) && !ctl_vld); // R1
endmodule

// File: tb/test_pi_voltage_reg.sv
module test_pi_voltage_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       samp_vld = 1'b0;
  logic [7:0] ref_smp = '0, meas_smp = '0;
  logic [7:0] ctl_out;
  logic       ctl_vld;
  int total = 0, bad = 0;
  int m_acc = 0, m_prev = 0;
  bit done = 0;
  localparam int BOUND = 255 * 4096;

  always #2.5 clk = ~clk;

  pi_voltage_reg i_pi_voltage_reg (
    .clk(clk), .rst_n(rst_n), .samp_vld(samp_vld), .ref_smp(ref_smp),
    .meas_smp(meas_smp), .ctl_out(ctl_out), .ctl_vld(ctl_vld));

  function automatic int floor_div(int a, int b);
    int r = ((a % b) + b) % b;
    return (a - r) / b;
  endfunction

  function automatic int model(int r, int m);
    int e = r - m;
    int s = m_acc + m_prev + e;
    int u;
    if (s > BOUND) s = BOUND;
    if (s < -BOUND) s = -BOUND;
    m_acc = s; m_prev = e;
    u = e * 10 + floor_div(s, 4096);
    if (u < 0) u = 0;
    if (u > 255) u = 255;
    return u;
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(int r, int m, int gap, string req);
    int exp = model(r, m);
    logic [7:0] held;
    samp_vld = 1'b1; ref_smp = 8'(r); meas_smp = 8'(m);
    @(negedge clk); samp_vld = 1'b0;
    @(negedge clk); chk("R7 early vld", int'(ctl_vld), 0);
    @(negedge clk); chk("R7 vld", int'(ctl_vld), 1);
    chk(req, int'(ctl_out), exp);
    held = ctl_out;
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      chk("R8 hold", int'(ctl_out), int'(held));
      chk("R7 single pulse", int'(ctl_vld), 0);
    end
    if (gap == 0) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    chk("R1 reset out", int'(ctl_out), 0);
    chk("R1 reset vld", int'(ctl_vld), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", int'(ctl_out), 0);
    // R1/R2/R3: first samples after reset, zero previous error
    send(100, 100, 1, "R2 zero error");
    send(120, 100, 1, "R3 positive error");
    send(100, 90, 5, "R4 trapezoid after gap");
    send(50, 60, 0, "R6 negative clamp");
    // R5: long positive windup
    for (int i = 0; i < 2200; i++) send(255, 0, 0, "R6 high rail");
    send(128, 128, 1, "R5 pos bound zero err");
    send(100, 120, 1, "R5 pos bound recovery");
    // R5: long negative windup
    for (int i = 0; i < 4200; i++) send(0, 255, 0, "R6 low rail");
    send(120, 100, 1, "R5 neg bound step1");
    send(130, 100, 1, "R5 neg bound step2");
    // reset clears integrator state (R1)
    rst_n = 1'b0; repeat (2) @(negedge clk);
    chk("R1 re-reset out", int'(ctl_out), 0);
    rst_n = 1'b1; m_acc = 0; m_prev = 0; @(negedge clk);
    send(140, 100, 1, "R1 cleared state");
    // R4/R6/R8: random mix
    for (int i = 0; i < 1500; i++) begin
      int r = int'($urandom_range(255));
      int m = ($urandom_range(3) == 0) ? int'($urandom_range(255))
            : ((r + int'($urandom_range(40)) - 20) & 255);
      send(r, m, int'($urandom_range(3)), "R4 random");
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R7 watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule